// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one command word into a run of asynchronous NAND bus cycles, clocked from a fast controller clock. A command selects a mode (write, read or wait-for-ready), one chip select, a target (command latch or data path), a keep-selected flag, an address-step flag and a byte count. Write bytes arrive on a valid/ready byte stream and read bytes leave on a second one. The strobe low and high widths and the setup gap before the first strobe come from configuration inputs counted in clock cycles. The busy timeout is counted in units of 4096 clocks.

The engine is a single state machine. Its states are IDLE (takes a command), SETUP (chip select and latch lines asserted, setup gap), LOW (strobe asserted), HIGH (strobe released), WAIT (polls the synchronised ready line) and FINISH (one-cycle completion). The transitions are as follows. IDLE goes to WAIT for a wait command, to FINISH for a zero count and otherwise to SETUP. SETUP goes to LOW once the gap has expired and the byte stream can move. LOW goes to HIGH when the low width expires. HIGH goes to FINISH after the last byte, or to LOW when the stream can move. WAIT goes to FINISH on ready or on timeout. FINISH always goes to IDLE.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is held, all chip enables are high, both strobes are high, CLE, ALE and the data output enable are low, `done` and `timeout` are low and `cmd_ready` is high.
- R2: A command is taken only in IDLE (`cmd_ready` high). During a command exactly the chip enable indexed by `cmd_cs` is low and no other.
- R3: The first strobe falls max(cfg_addr_setup,1) cycles after the accepting edge plus one cycle. In other words, the SETUP state lasts max(cfg_addr_setup,1) cycles.
- R4: Each strobe stays low for max(cfg_data_setup,1) cycles and, between bytes of a transfer that is not stalled, high for max(cfg_data_hold,1) cycles. `done` follows the last strobe fall after max(setup,1)+max(hold,1) cycles.
- R5: Write mode (`cmd_mode`=0) pulses WE# once per byte and never RE#. It takes bytes from the write stream in order and drives each one on `nand_dq_out` with `nand_dq_oe` high for the whole low phase. The output enable is never high while RE# is low.
- R6: Read mode (`cmd_mode`=1) pulses RE# once per byte and never WE#. It samples `nand_dq_in` at the RE# rising edge and presents the bytes in order on the read stream. `rd_valid` and `rd_data` hold until `rd_ready` is seen.
- R7: No strobe falls while the write stream has no valid byte (write mode) or while an earlier read byte is still held (read mode).
- R8: Target 0 (data) keeps CLE and ALE low. Target 1 (command latch) raises CLE for every byte when `cmd_addr_inc` is 0. With `cmd_addr_inc` 1 it raises CLE for the first byte and ALE for every later byte. CLE and ALE are never high together.
- R9: A read or write command with count 0 produces no strobe, and `done` is high in the cycle after acceptance. A wait command (`cmd_mode` 2 or 3) produces no strobe whatever its count.
- R10: `nand_rb` passes through a two-flop synchroniser. A wait command whose ready line is already steadily high completes with `done` two cycles after acceptance. A ready rise gives `done` three cycles after the rise, with `timeout` low.
- R11: With the ready line low, a wait command spends 4096*cfg_busy_timeout+1 cycles in WAIT and then pulses `done` together with `timeout`.
- R12: After a command with `cmd_lock`=1, the selected chip enable stays low in IDLE until the next command completes without the lock. After a command without the lock, all chip enables return high.
- R13: `done` is a one-cycle pulse per command and `timeout` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_mode | input | 2 | 0 write, 1 read, 2 or 3 wait-for-ready |
| cmd_cs | input | CS_W | Chip select index |
| cmd_target | input | 1 | 0 data path, 1 command latch |
| cmd_lock | input | 1 | Keep chip enable asserted after completion |
| cmd_addr_inc | input | 1 | Step from CLE to ALE after the first byte |
| cmd_count | input | CNT_W | Byte cycles to run |
| cfg_addr_setup | input | TIME_W | Setup gap before the first strobe, in cycles |
| cfg_data_setup | input | TIME_W | Strobe low width, in cycles |
| cfg_data_hold | input | TIME_W | Strobe high width, in cycles |
| cfg_busy_timeout | input | TO_W | Ready timeout in units of 4096 cycles |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken at this edge when valid |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumer ready |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| done | output | 1 | Command completed |
| timeout | output | 1 | Wait command ended without ready |

## Verification
The stall paths are the hardest to reach from the ports, because a strobe may only be held back at the boundary between the setup gap or a high phase and the next low phase. The bench holds the write stream empty, or leaves a read byte unconsumed, across that boundary for a chosen number of cycles. It then predicts the exact cycle of the delayed fall. The timeout boundary is forced by holding the ready line low with a timeout of zero and of one unit. Both cases give arithmetic cycle counts of 2 and 4098.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [1:0] MODE_WRITE = 2'd0;
    localparam logic [1:0] MODE_READ  = 2'd1;

    localparam int unsigned WAIT_PRE_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_WAIT,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_sync
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= rb_async;
            sync_q <= meta_q;
        end
    end

    assign rb_sync = sync_q;
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] value,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (value == '0) ? '0 : value - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
    parameter int unsigned PRE_W = 12,
    parameter int unsigned TO_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [TO_W-1:0] limit,
    output logic            elapsed
);
    logic [PRE_W-1:0] pre_q;
    logic [TO_W-1:0]  unit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (clear) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (pre_q == '1 && unit_q != '1) begin
                unit_q <= unit_q + 1'b1;
            end
        end
    end

    assign elapsed = (unit_q == limit);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned TIME_W = 8,
    parameter int unsigned TO_W   = 16,
    localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic              cmd_target,
    input  logic              cmd_lock,
    input  logic              cmd_addr_inc,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [TIME_W-1:0] cfg_addr_setup,
    input  logic [TIME_W-1:0] cfg_data_setup,
    input  logic [TIME_W-1:0] cfg_data_hold,
    input  logic [TO_W-1:0]   cfg_busy_timeout,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rb,
    output logic              done,
    output logic              timeout
);
    seq_state_e        state_q, next_s;
    logic [CS_W-1:0]   cs_q;
    logic              tgt_q, lock_q, inc_q, rd_mode_q, first_q;
    logic              hold_ce_q, tmo_q, rd_valid_q;
    logic [CNT_W-1:0]  left_q;
    logic [7:0]        dq_q, rd_data_q;
    logic              rdy_s, phase_done, wait_elapsed, stream_ok, accept;
    logic              in_xfer;
    logic [TIME_W-1:0] phase_len;
    logic [NUM_CS-1:0] ce_vec;

    nand_rb_sync u_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .rb_sync  (rdy_s)
    );

    nand_phase_timer #(.WIDTH(TIME_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (next_s != state_q),
        .value   (phase_len),
        .expired (phase_done)
    );

    nand_wait_timer #(.PRE_W(WAIT_PRE_W), .TO_W(TO_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_WAIT),
        .limit   (cfg_busy_timeout),
        .elapsed (wait_elapsed)
    );

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign stream_ok = rd_mode_q ? (!rd_valid_q || rd_ready) : wr_valid;

    // Next-state logic
    always_comb begin
        next_s = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_mode[1])            next_s = ST_WAIT;
                    else if (cmd_count == '0)   next_s = ST_FINISH;
                    else                        next_s = ST_SETUP;
                end
            end
            ST_SETUP:  if (phase_done && stream_ok) next_s = ST_LOW;
            ST_LOW:    if (phase_done) next_s = ST_HIGH;
            ST_HIGH: begin
                if (phase_done) begin
                    if (left_q == '0)   next_s = ST_FINISH;
                    else if (stream_ok) next_s = ST_LOW;
                end
            end
            ST_WAIT:   if (rdy_s || wait_elapsed) next_s = ST_FINISH;
            ST_FINISH: next_s = ST_IDLE;
            default:   next_s = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (next_s)
            ST_SETUP: phase_len = cfg_addr_setup;
            ST_LOW:   phase_len = cfg_data_setup;
            ST_HIGH:  phase_len = cfg_data_hold;
            default:  phase_len = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= next_s;
    end

    // Command context and data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q       <= '0;
            tgt_q      <= 1'b0;
            lock_q     <= 1'b0;
            inc_q      <= 1'b0;
            rd_mode_q  <= 1'b0;
            first_q    <= 1'b0;
            left_q     <= '0;
            dq_q       <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            tmo_q      <= 1'b0;
            hold_ce_q  <= 1'b0;
        end else begin
            if (accept) begin
                cs_q      <= cmd_cs;
                tgt_q     <= cmd_target;
                lock_q    <= cmd_lock;
                inc_q     <= cmd_addr_inc;
                rd_mode_q <= (cmd_mode == MODE_READ);
                left_q    <= cmd_count;
                first_q   <= 1'b1;
                tmo_q     <= 1'b0;
            end
            if (state_q == ST_LOW && next_s == ST_HIGH) left_q <= left_q - 1'b1;
            if (state_q == ST_HIGH && next_s == ST_LOW) first_q <= 1'b0;
            if (wr_ready && wr_valid) dq_q <= wr_data;
            if (rd_mode_q && state_q == ST_LOW && phase_done) begin
                rd_data_q  <= nand_dq_in;
                rd_valid_q <= 1'b1;
            end else if (rd_ready) begin
                rd_valid_q <= 1'b0;
            end
            if (state_q == ST_WAIT)   tmo_q     <= !rdy_s;
            if (state_q == ST_FINISH) hold_ce_q <= lock_q;
        end
    end

    // Output decode
    always_comb begin
        in_xfer     = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
        ce_vec      = '0;
        if (state_q != ST_IDLE || hold_ce_q) ce_vec[cs_q] = 1'b1;
        nand_ce_n   = ~ce_vec;
        nand_we_n   = !(state_q == ST_LOW && !rd_mode_q);
        nand_re_n   = !(state_q == ST_LOW && rd_mode_q);
        nand_cle    = in_xfer && tgt_q && (!inc_q || first_q);
        nand_ale    = in_xfer && tgt_q && inc_q && !first_q;
        nand_dq_oe  = !rd_mode_q && (state_q == ST_LOW || state_q == ST_HIGH);
        nand_dq_out = dq_q;
        wr_ready    = !rd_mode_q && phase_done &&
                      ((state_q == ST_SETUP) || (state_q == ST_HIGH && left_q != '0));
        rd_data     = rd_data_q;
        rd_valid    = rd_valid_q;
        done        = (state_q == ST_FINISH);
        timeout     = (state_q == ST_FINISH) && tmo_q;
    end

    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));
    // R5
    oe_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> nand_re_n);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R7
    we_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> $past(wr_valid));
    // R8
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R13
    timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_nand_cycle_seq.sv
`timescale 1ns/1ps
module test_nand_cycle_seq;
    localparam int NCS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_mode = 2'd0;
    logic [1:0] cmd_cs = 2'd0;
    logic       cmd_target = 1'b0, cmd_lock = 1'b0, cmd_addr_inc = 1'b0;
    logic [11:0] cmd_count = '0;
    logic [7:0] cfg_a = 8'd1, cfg_s = 8'd1, cfg_h = 8'd1;
    logic [15:0] cfg_to = 16'd1;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b0, wr_ready;
    logic [7:0] rd_data;
    logic       rd_valid, rd_ready = 1'b1;
    logic [NCS-1:0] ce_n;
    logic       cle, ale, we_n, re_n, dq_oe, done, timeout;
    logic [7:0] dq_out, dq_in = '0;
    logic       rb = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    nand_cycle_seq i_nand_cycle_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_cs(cmd_cs), .cmd_target(cmd_target),
        .cmd_lock(cmd_lock), .cmd_addr_inc(cmd_addr_inc), .cmd_count(cmd_count),
        .cfg_addr_setup(cfg_a), .cfg_data_setup(cfg_s), .cfg_data_hold(cfg_h),
        .cfg_busy_timeout(cfg_to), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
        .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_out(dq_out),
        .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .nand_rb(rb),
        .done(done), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wr_pat(input int i);
        return 8'(8'h3C + i * 29);
    endfunction

    function automatic logic [7:0] rd_pat(input int i);
        return 8'(8'hC5 ^ (i * 13));
    endfunction

    function automatic int atl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [NCS-1:0] ce_exp(input int cs);
        return ~(NCS'(1) << cs);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Read or write transfer; stall>0 holds the stream back until that cycle
    task automatic run_xfer(input int mode, input int tgt, input int inc, input int lock,
                            input int cs, input int cnt, input int stall);
        int ae = atl1(cfg_a), se = atl1(cfg_s), he = atl1(cfg_h);
        int k = 1, falls = 0, lo_run = 0, widx = 0, ridx = 0;
        int exp_fall, exp_done, last_fall = 0;
        bit prev_lo = 0, lo, consumed = 0, bad_other = 0, bad_oe = 0, fin = 0;
        logic [7:0] last_dq = '0;
        logic last_oe = 0;
        @(negedge clk);
        cmd_mode = 2'(mode); cmd_target = 1'(tgt); cmd_addr_inc = 1'(inc);
        cmd_lock = 1'(lock); cmd_cs = 2'(cs); cmd_count = 12'(cnt); cmd_valid = 1'b1;
        wr_valid = (mode == 0) && (stall == 0);
        rd_ready = !((mode == 1) && (stall != 0));
        wr_data  = wr_pat(0);
        exp_fall = (mode == 0 && stall != 0 && stall + 1 > ae + 1) ? stall + 1 : ae + 1;
        exp_done = (cnt == 0) ? 1 : -1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!fin && k < 3000) begin
            lo = (mode == 0) ? !we_n : !re_n;
            if ((mode == 0 && !re_n) || (mode == 1 && !we_n)) bad_other = 1;
            if (!re_n && dq_oe) bad_oe = 1;
            if (lo && !prev_lo) begin
                chk(k == exp_fall, "R3/R4/R7 strobe fall cycle", k, exp_fall);
                chk(ce_n == ce_exp(cs), "R2 chip enable", int'(ce_n), int'(ce_exp(cs)));
                chk(cle == (tgt == 1 && (inc == 0 || falls == 0)), "R8 CLE level", cle, 0);
                chk(ale == (tgt == 1 && inc == 1 && falls != 0), "R8 ALE level", ale, 0);
                last_fall = k;
                falls++;
                lo_run = 1;
                exp_fall = k + se + he;
                if (mode == 1 && falls == 1 && stall != 0 && stall + 1 > exp_fall)
                    exp_fall = stall + 1;
                if (falls == cnt) exp_done = k + se + he;
            end else if (lo) begin
                lo_run++;
            end
            if (!lo && prev_lo) begin
                chk(lo_run == se, "R4 strobe low width", lo_run, se);
                if (mode == 0) begin
                    chk(last_dq == wr_pat(falls - 1), "R5 write byte on bus", last_dq, wr_pat(falls - 1));
                    chk(last_oe == 1'b1, "R5 output enable during write", last_oe, 1);
                end
            end
            if (lo) begin
                last_dq = dq_out;
                last_oe = dq_oe;
                if (mode == 1) dq_in = rd_pat(falls - 1);
            end
            prev_lo = lo;
            if (done) begin
                chk(k == exp_done, "R4/R9 done cycle", k, exp_done);
                chk(timeout == 1'b0, "R13 no timeout on transfer", timeout, 0);
                fin = 1;
            end
            if (consumed) begin
                widx++;
                wr_data = wr_pat(widx);
            end
            if (k == stall) begin
                if (mode == 0) wr_valid = 1'b1;
                else rd_ready = 1'b1;
            end
            consumed = wr_valid && wr_ready;
            if (rd_valid && rd_ready && mode == 1) begin
                chk(rd_data == rd_pat(ridx), "R6 read byte order", rd_data, rd_pat(ridx));
                ridx++;
            end
            if (!fin) begin
                @(negedge clk);
                k++;
            end
        end
        chk(fin, "R4 transfer completes", k, exp_done);
        chk(falls == cnt, "R5/R6/R9 strobe count", falls, cnt);
        chk(!bad_other && !bad_oe, "R5/R6 other strobe and enable idle", int'(bad_other), 0);
        if (mode == 0) chk(widx + int'(consumed) == cnt, "R5 write bytes taken", widx + int'(consumed), cnt);
        if (mode == 1) chk(ridx == cnt, "R6 read bytes delivered", ridx, cnt);
        wr_valid = 1'b0;
        rd_ready = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R13 done is a pulse", done, 0);
        chk(cmd_ready == 1'b1, "R2 ready after completion", cmd_ready, 1);
        if (lock != 0) chk(ce_n == ce_exp(cs), "R12 chip enable held", int'(ce_n), int'(ce_exp(cs)));
        else           chk(ce_n == '1, "R12 chip enable released", int'(ce_n), 15);
    endtask

    // Wait-for-ready; rel>0 raises the ready line at that cycle
    task automatic run_wait(input int cnt, input int rel, input int exp_k, input bit exp_to);
        int k = 1;
        bit fin = 0, strobed = 0;
        @(negedge clk);
        cmd_mode = 2'd2; cmd_count = 12'(cnt); cmd_target = 1'b1; cmd_lock = 1'b0;
        cmd_cs = 2'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!fin && k < 20000) begin
            if (!we_n || !re_n || cle || ale) strobed = 1;
            if (done) begin
                chk(k == exp_k, "R10/R11 wait completion cycle", k, exp_k);
                chk(timeout == exp_to, "R11/R13 timeout flag", timeout, int'(exp_to));
                fin = 1;
            end
            if (k == rel) rb = 1'b1;
            if (!fin) begin
                @(negedge clk);
                k++;
            end
        end
        chk(fin, "R10 wait completes", k, exp_k);
        chk(!strobed, "R9 no cycles in wait mode", int'(strobed), 0);
        @(negedge clk);
        chk(timeout == 1'b0, "R13 timeout is a pulse", timeout, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n == '1 && we_n && re_n, "R1 reset strobes and enables", int'(ce_n), 15);
        chk(!cle && !ale && !dq_oe && !done && !timeout && cmd_ready,
            "R1 reset latches, enable and flags", int'({cle, ale, dq_oe, done, timeout}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R8: sweep of setup, low and high widths on command-then-address writes
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 3; s++)
                for (int h = 0; h < 3; h++) begin
                    cfg_a = 8'(a); cfg_s = 8'(s); cfg_h = 8'(h);
                    run_xfer(0, 1, 1, 0, (a + s) % NCS, 3, 0);
                end

        // R6: read sweep on the data path
        cfg_a = 8'd1;
        for (int s = 0; s < 3; s++)
            for (int h = 0; h < 3; h++) begin
                cfg_s = 8'(s); cfg_h = 8'(h);
                run_xfer(1, 0, 0, 0, h, 2, 0);
            end

        cfg_a = 8'd2; cfg_s = 8'd2; cfg_h = 8'd1;
        run_xfer(0, 1, 0, 0, 2, 2, 0);   // R8 CLE on every byte
        run_xfer(0, 0, 1, 0, 3, 4, 0);   // R8 data target, no latch lines
        run_xfer(0, 0, 0, 0, 0, 0, 0);   // R9 count zero
        run_xfer(1, 0, 0, 0, 0, 0, 0);   // R9 count zero read
        run_xfer(0, 0, 0, 0, 1, 3, 20);  // R7 write stall
        run_xfer(1, 0, 0, 0, 2, 3, 30);  // R7 read stall
        run_xfer(0, 1, 1, 1, 3, 2, 0);   // R12 lock
        run_xfer(1, 0, 0, 1, 3, 1, 0);   // R12 still held
        run_xfer(0, 0, 0, 0, 3, 1, 0);   // R12 released

        rb = 1'b1;
        run_wait(0, 0, 2, 0);            // R10 already ready
        rb = 1'b0;
        run_wait(5, 10, 13, 0);          // R10 ready rise, R9 count ignored
        rb = 1'b0;
        cfg_to = 16'd0;
        run_wait(0, 0, 2, 1);            // R11 zero timeout
        cfg_to = 16'd1;
        run_wait(0, 0, 4098, 1);         // R11 one unit
        rb = 1'b1;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule